// File: doc/BRIEF.md
# Bridge Termination Status Handler

This block sits on the upstream side of a host-to-PCI bridge. Each time a downstream cycle that the upstream side started comes to an end, it receives one strobe with the cycle's class, direction and termination. From these it works out what goes back upstream: a completion with status and data, a system-error message request, or nothing. It also keeps the sticky error bits of the primary and secondary status registers.

Cycles come in two classes. A completion-required cycle always gets a completion whose status mirrors the downstream termination. On a read abort the data is forced to all ones, and the Master Abort Mode bit is not looked at. A posted write never gets a completion. Its aborts can raise a system-error request, gated by the mode bit for master aborts and by the SERR enable for every case. Software clears status bits by writing ones to a mask.

Top module: `bridge_term_status`

## Requirements
- R1: While reset is held and on the first clock after it, `cplValid`, `serrReq`, `cplStatus`, `cplData` and all of `statusBits` are zero.
- R2: A completion-required cycle (`cycPosted`=0) sampled with `cycDone`=1 gives `cplValid`=1 for exactly the next clock. `cplStatus` then equals the termination code: 00 successful, 01 master abort, 10 target abort. The reserved code 11 is handled like 00.
- R3: A completion-required read ending in master or target abort returns `cplData` all ones. A successful read returns `rdData` as sampled with `cycDone`. A completion for a write carries zero data.
- R4: The completion status, data and status bits of a completion-required cycle are the same whatever `maMode` is.
- R5: A completion-required master abort sets `statusBits[2]` (secondary received master abort). A completion-required target abort sets `statusBits[1]` (secondary received target abort) and `statusBits[3]` (primary signaled target abort).
- R6: `statusBits[0]` (secondary master data parity error) is set by a finished cycle of either class only when `dataParErr`=1 with it.
- R7: A posted write that completes successfully asserts no output and sets no status bit.
- R8: A posted write ending in master abort always sets `statusBits[2]`. It requests a system error only when `maMode`=1.
- R9: A posted write ending in target abort sets `statusBits[1]` and requests a system error whatever `maMode` is.
- R10: A system-error request is a one-clock `serrReq` pulse in the clock after `cycDone`. `statusBits[4]` (primary signaled system error) is set with it. Neither happens when `serrEn`=0.
- R11: Status bits are sticky. A bit clears only on a clock where `stsClrEn`=1 with a one in that position of `stsClrMask`. If a set event hits the same bit on that clock, the bit stays set.
- R12: On a clock with `cycDone`=0, no status bit is set, and neither `cplValid` nor `serrReq` is asserted on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycDone | input | 1 | A downstream cycle finished this clock |
| cycPosted | input | 1 | 1 = posted write, 0 = completion-required |
| cycRead | input | 1 | 1 = read cycle |
| termType | input | 2 | Termination code (00 ok, 01 master abort, 10 target abort) |
| dataParErr | input | 1 | Data parity error seen downstream |
| maMode | input | 1 | Master Abort Mode control bit |
| serrEn | input | 1 | SERR enable from the primary command register |
| rdData | input | DATA_W | Read data from downstream |
| stsClrEn | input | 1 | Software write-one-to-clear strobe |
| stsClrMask | input | 5 | Bits to clear |
| cplValid | output | 1 | Completion valid, one clock |
| cplStatus | output | 2 | Completion status code |
| cplData | output | DATA_W | Completion data |
| serrReq | output | 1 | System-error message request pulse |
| statusBits | output | 5 | Sticky status: [0] mdpe, [1] rcv TA, [2] rcv MA, [3] sig TA, [4] sig SE |

## Verification
All results are registered once. A cycle presented with `cycDone` on one clock edge shows its completion, system-error pulse and status bits right after the next rising edge. The pulse is gone one clock later. The bench drives inputs on falling edges and samples on the falling edge that follows the capturing rising edge. It samples `serrReq` and `cplValid` a second time one clock later to prove they are single pulses. The clear tests sample the status bits one edge after the clear, the same way.

// File: rtl/bts_pkg.sv
package bts_pkg;

  localparam int STS_W = 5;

  // status bit positions
  localparam int STS_MDPE = 0;
  localparam int STS_RTA  = 1;
  localparam int STS_RMA  = 2;
  localparam int STS_STA  = 3;
  localparam int STS_SSE  = 4;

  typedef enum logic [1:0] {
    TERM_OK  = 2'b00,
    TERM_MA  = 2'b01,
    TERM_TA  = 2'b10,
    TERM_RSV = 2'b11
  } term_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             cplFire;
    logic             onesFill;
    logic             passData;
    logic             serrFire;
    term_t            cplCode;
    logic [STS_W-1:0] setBits;
  } ctrlStrobes_t;

endpackage

// File: rtl/bts_ctrl.sv
module bts_ctrl
  import bts_pkg::*;
(
  input  logic         cycDone,
  input  logic         cycPosted,
  input  logic         cycRead,
  input  logic [1:0]   termType,
  input  logic         dataParErr,
  input  logic         maMode,
  input  logic         serrEn,
  output ctrlStrobes_t strobes
);

  term_t termNorm;
  logic  isMa;
  logic  isTa;
  logic  postedSerr;

  always_comb begin
    unique case (termType)
      2'b01:   termNorm = TERM_MA;
      2'b10:   termNorm = TERM_TA;
      default: termNorm = TERM_OK;
    endcase
  end

  assign isMa = (termNorm == TERM_MA);
  assign isTa = (termNorm == TERM_TA);

  // posted writes: TA always escalates, MA only under mode bit; all gated by enable
  assign postedSerr = serrEn && (isTa || (isMa && maMode));

  always_comb begin
    strobes = '0;
    if (cycDone) begin
      strobes.setBits[STS_MDPE] = dataParErr;
      strobes.setBits[STS_RMA]  = isMa;
      strobes.setBits[STS_RTA]  = isTa;
      if (!cycPosted) begin
        strobes.cplFire           = 1'b1;
        strobes.cplCode           = termNorm;
        strobes.onesFill          = cycRead && (isMa || isTa);
        strobes.passData          = cycRead && !(isMa || isTa);
        strobes.setBits[STS_STA]  = isTa;
      end else begin
        strobes.serrFire          = postedSerr;
        strobes.setBits[STS_SSE]  = postedSerr;
      end
    end
  end

endmodule

// File: rtl/bts_datapath.sv
module bts_datapath
  import bts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] rdData,
  input  logic              stsClrEn,
  input  logic [STS_W-1:0]  stsClrMask,
  output logic              cplValid,
  output logic [1:0]        cplStatus,
  output logic [DATA_W-1:0] cplData,
  output logic              serrReq,
  output logic [STS_W-1:0]  statusBits
);

  logic [STS_W-1:0]  clrVec;
  logic [DATA_W-1:0] dataNext;

  assign clrVec = stsClrEn ? stsClrMask : '0;

  always_comb begin
    if (strobes.onesFill)      dataNext = '1;
    else if (strobes.passData) dataNext = rdData;
    else                       dataNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cplValid  <= 1'b0;
      cplStatus <= 2'b00;
      cplData   <= '0;
      serrReq   <= 1'b0;
    end else begin
      cplValid  <= strobes.cplFire;
      cplStatus <= strobes.cplFire ? strobes.cplCode : 2'b00;
      cplData   <= strobes.cplFire ? dataNext : '0;
      serrReq   <= strobes.serrFire;
    end
  end

  // one sticky cell per bit; set has priority over clear
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN)                   statusBits[i] <= 1'b0;
      else if (strobes.setBits[i]) statusBits[i] <= 1'b1;
      else if (clrVec[i])          statusBits[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/bridge_term_status.sv
module bridge_term_status
  import bts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycDone,
  input  logic              cycPosted,
  input  logic              cycRead,
  input  logic [1:0]        termType,
  input  logic              dataParErr,
  input  logic              maMode,
  input  logic              serrEn,
  input  logic [DATA_W-1:0] rdData,
  input  logic              stsClrEn,
  input  logic [4:0]        stsClrMask,
  output logic              cplValid,
  output logic [1:0]        cplStatus,
  output logic [DATA_W-1:0] cplData,
  output logic              serrReq,
  output logic [4:0]        statusBits
);

  ctrlStrobes_t strobes;

  bts_ctrl u_ctrl (
    .cycDone    (cycDone),
    .cycPosted  (cycPosted),
    .cycRead    (cycRead),
    .termType   (termType),
    .dataParErr (dataParErr),
    .maMode     (maMode),
    .serrEn     (serrEn),
    .strobes    (strobes)
  );

  bts_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdData     (rdData),
    .stsClrEn   (stsClrEn),
    .stsClrMask (stsClrMask),
    .cplValid   (cplValid),
    .cplStatus  (cplStatus),
    .cplData    (cplData),
    .serrReq    (serrReq),
    .statusBits (statusBits)
  );

endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycDone,
  input logic              cycPosted,
  input logic              cycRead,
  input logic              serrEn,
  input logic              stsClrEn,
  input logic [4:0]        stsClrMask,
  input logic              cplValid,
  input logic [1:0]        cplStatus,
  input logic [DATA_W-1:0] cplData,
  input logic              serrReq,
  input logic [4:0]        statusBits
);

  // R2: completions only follow completion-required cycles
  p_cpl_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> $past(cycDone && !cycPosted));

  // R3: aborted reads return all ones
  p_abort_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplStatus != 2'b00 && $past(cycRead)) |-> (&cplData));

  // R10: system error needs a posted cycle with the enable set
  p_serr_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    serrReq |-> $past(cycDone && cycPosted && serrEn));

  // R10: signaled system error bit accompanies the request
  p_serr_bit_r10: assert property (@(posedge clk) disable iff (!rstN)
    serrReq |-> statusBits[4]);

  // R12: nothing fires without a done strobe
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cycDone |=> (!cplValid && !serrReq));

  // R11: bits hold unless cleared
  for (genvar b = 0; b < 5; b++) begin : g_stk
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
      (statusBits[b] && !(stsClrEn && stsClrMask[b])) |=> statusBits[b]);
  end

endmodule

bind bridge_term_status bts_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycDone    (cycDone),
  .cycPosted  (cycPosted),
  .cycRead    (cycRead),
  .serrEn     (serrEn),
  .stsClrEn   (stsClrEn),
  .stsClrMask (stsClrMask),
  .cplValid   (cplValid),
  .cplStatus  (cplStatus),
  .cplData    (cplData),
  .serrReq    (serrReq),
  .statusBits (statusBits)
);

// File: tb/bridge_term_status_test.sv
module bridge_term_status_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cycDone, cycPosted, cycRead, dataParErr, maMode, serrEn, stsClrEn;
  logic [1:0]    termType;
  logic [DW-1:0] rdData;
  logic [4:0]    stsClrMask;
  logic          cplValid, serrReq;
  logic [1:0]    cplStatus;
  logic [DW-1:0] cplData;
  logic [4:0]    statusBits;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bridge_term_status #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .cycDone(cycDone), .cycPosted(cycPosted),
    .cycRead(cycRead), .termType(termType), .dataParErr(dataParErr),
    .maMode(maMode), .serrEn(serrEn), .rdData(rdData),
    .stsClrEn(stsClrEn), .stsClrMask(stsClrMask), .cplValid(cplValid),
    .cplStatus(cplStatus), .cplData(cplData), .serrReq(serrReq),
    .statusBits(statusBits)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    cycDone = 0; cycPosted = 0; cycRead = 0; termType = 2'b00;
    dataParErr = 0; maMode = 0; serrEn = 0; rdData = '0;
    stsClrEn = 0; stsClrMask = '0;
  endtask

  // clear every status bit, one clock
  task automatic clearAll();
    @(negedge clk);
    idleInputs();
    stsClrEn = 1; stsClrMask = 5'h1f;
    @(negedge clk);
    idleInputs();
  endtask

  // drive one finished cycle; return after outputs have registered
  task automatic runCycle(bit posted, bit rd, logic [1:0] term, bit perr,
                          bit mam, bit sen, logic [DW-1:0] data);
    @(negedge clk);
    cycDone = 1; cycPosted = posted; cycRead = rd; termType = term;
    dataParErr = perr; maMode = mam; serrEn = sen; rdData = data;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic expectCycle(string req, bit v, logic [1:0] st,
                             logic [DW-1:0] d, bit se, logic [4:0] sts);
    chk({req, " cplValid"},  cplValid, v);
    if (v) begin
      chk({req, " cplStatus"}, cplStatus, st);
      chk({req, " cplData"},   cplData, d);
    end
    chk({req, " serrReq"},    serrReq, se);
    chk({req, " statusBits"}, statusBits, sts);
    @(negedge clk);
    chk({req, " pulse ends"}, {cplValid, serrReq}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 cplValid", cplValid, 0);
    chk("R1 serrReq", serrReq, 0);
    chk("R1 cplStatus", cplStatus, 0);
    chk("R1 cplData", cplData, 0);
    chk("R1 statusBits", statusBits, 0);
  endtask

  task automatic t_cr_reads();
    clearAll();
    runCycle(0, 1, 2'b00, 0, 0, 1, 32'h1234_5678);
    expectCycle("R2 R3 read ok", 1, 2'b00, 32'h1234_5678, 0, 5'b00000);
    runCycle(0, 1, 2'b11, 0, 1, 1, 32'h0bad_cafe);
    expectCycle("R2 reserved as ok", 1, 2'b00, 32'h0bad_cafe, 0, 5'b00000);
    runCycle(0, 1, 2'b01, 0, 0, 1, 32'h5555_0000);
    expectCycle("R3 R5 read MA", 1, 2'b01, '1, 0, 5'b00100);
    clearAll();
    runCycle(0, 1, 2'b01, 0, 1, 1, 32'h5555_0000);
    expectCycle("R4 read MA maMode1", 1, 2'b01, '1, 0, 5'b00100);
    clearAll();
    runCycle(0, 1, 2'b10, 0, 1, 1, 32'h0);
    expectCycle("R5 read TA", 1, 2'b10, '1, 0, 5'b01010);
    clearAll();
    runCycle(0, 0, 2'b10, 0, 0, 0, 32'h7);
    expectCycle("R3 R5 write TA", 1, 2'b10, 32'h0, 0, 5'b01010);
  endtask

  task automatic t_parity();
    clearAll();
    runCycle(0, 1, 2'b00, 0, 0, 0, 32'h1);
    expectCycle("R6 no perr", 1, 2'b00, 32'h1, 0, 5'b00000);
    runCycle(0, 1, 2'b00, 1, 0, 0, 32'h1);
    expectCycle("R6 cr perr", 1, 2'b00, 32'h1, 0, 5'b00001);
    clearAll();
    runCycle(1, 0, 2'b00, 1, 0, 0, 32'h0);
    expectCycle("R6 posted perr", 0, 2'b00, 32'h0, 0, 5'b00001);
  endtask

  task automatic t_posted();
    clearAll();
    runCycle(1, 0, 2'b00, 0, 1, 1, 32'h9);
    expectCycle("R7 posted ok", 0, 2'b00, 32'h0, 0, 5'b00000);
    runCycle(1, 0, 2'b01, 0, 1, 1, 32'h0);
    expectCycle("R8 R10 posted MA mam1", 0, 2'b00, 32'h0, 1, 5'b10100);
    clearAll();
    runCycle(1, 0, 2'b01, 0, 0, 1, 32'h0);
    expectCycle("R8 posted MA mam0", 0, 2'b00, 32'h0, 0, 5'b00100);
    clearAll();
    runCycle(1, 0, 2'b01, 0, 1, 0, 32'h0);
    expectCycle("R10 posted MA no enable", 0, 2'b00, 32'h0, 0, 5'b00100);
    clearAll();
    runCycle(1, 0, 2'b10, 0, 0, 1, 32'h0);
    expectCycle("R9 posted TA mam0", 0, 2'b00, 32'h0, 1, 5'b10010);
    clearAll();
    runCycle(1, 0, 2'b10, 0, 1, 0, 32'h0);
    expectCycle("R9 R10 posted TA no enable", 0, 2'b00, 32'h0, 0, 5'b00010);
  endtask

  task automatic t_clear();
    clearAll();
    runCycle(0, 1, 2'b10, 1, 0, 0, 32'h0);
    chk("R11 setup", statusBits, 5'b01011);
    @(negedge clk);
    chk("R11 held", statusBits, 5'b01011);
    stsClrEn = 1; stsClrMask = 5'b01000;
    @(negedge clk);
    idleInputs();
    chk("R11 partial clear", statusBits, 5'b00011);
    stsClrMask = 5'b00011;
    @(negedge clk);
    chk("R11 mask without enable", statusBits, 5'b00011);
    // clear and set of the same bit together
    cycDone = 1; cycPosted = 1; termType = 2'b10;
    stsClrEn = 1; stsClrMask = 5'b00011;
    @(negedge clk);
    idleInputs();
    chk("R11 set wins", statusBits, 5'b00010);
  endtask

  task automatic t_idle();
    clearAll();
    @(negedge clk);
    cycDone = 0; cycPosted = 1; termType = 2'b10; dataParErr = 1;
    maMode = 1; serrEn = 1; cycRead = 1;
    @(negedge clk);
    chk("R12 no cpl", cplValid, 0);
    chk("R12 no serr", serrReq, 0);
    chk("R12 no bits", statusBits, 0);
    cycPosted = 0;
    @(negedge clk);
    chk("R12 cr idle", {cplValid, serrReq, statusBits}, 7'd0);
    idleInputs();
  endtask

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_cr_reads();
    t_parity();
    t_posted();
    t_clear();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule